// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the ALU of a five-stage, 32-bit load/store pipeline. It chooses the value of each of the two register operands used by the instruction in the execute stage. For each operand it compares the operand's source register number with the destination of the older instruction in the memory stage and with the destination of the oldest instruction in the write-back stage. It then passes on one of three values: the register-file read value, the memory stage's ALU result, or a value that the write-back stage holds.

The block is purely combinational. It has no clock and no state. Each operand also has a flag that reports when the register-file value has been replaced. The selection rules have three deliberate restrictions:

- A store anywhere in the execute, memory or write-back stage suppresses all bypassing.
- The write-back value offered depends on the instruction class of the consumer.
- The second operand takes a memory-stage value only when the consumer reads that operand from a register.

Stall generation and the register file are outside this block.

Top module: `fwd_unit`

## Requirements
- R1: A producer's destination register is its rd field when its register-destination control is 1, and its rt field when that control is 0.
- R2: A producer in the memory or write-back stage whose register-write control is 0 never supplies either operand.
- R3: When the store (memory-write) control is 1 in the execute, memory or write-back stage, both operands equal their register-file values and both flags are 0.
- R4: When the memory-stage and write-back-stage destinations both match an operand's source register and both stages may supply it, the memory-stage value is chosen.
- R5: When the first operand (rs) is bypassed from write-back, it takes the write-back ALU result if the consumer's ALU-op code is 3 (immediate class). For any other code it takes the write-back load data.
- R6: The second operand (rt) is never bypassed from write-back when the consumer's ALU-op code is 3. For any other code a write-back match supplies the write-back load data.
- R7: The second operand is bypassed from the memory stage only when the consumer's ALU-source control is 0 (register operand). The first operand ignores that control.
- R8: A memory-stage bypass always supplies the memory stage's ALU result.
- R9: A producer whose destination is register 0 never supplies an operand.
- R10: With no usable match, each operand equals its register-file value.
- R11: Each flag is 1 exactly when its operand differs in source from the register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | Execute-stage first source register |
| ex_rt | input | 5 | Execute-stage second source register |
| ex_alusrc | input | 1 | Consumer takes immediate instead of rt (1) |
| ex_aluop | input | 2 | Consumer ALU-op class code (3 = immediate ALU op) |
| ex_memwrite | input | 1 | Execute-stage instruction is a store |
| mem_rt | input | 5 | Memory-stage rt field |
| mem_rd | input | 5 | Memory-stage rd field |
| mem_regdst | input | 1 | Memory-stage destination is rd (1) or rt (0) |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memwrite | input | 1 | Memory-stage instruction is a store |
| mem_alu_result | input | 32 | Memory-stage ALU result |
| wb_rt | input | 5 | Write-back-stage rt field |
| wb_rd | input | 5 | Write-back-stage rd field |
| wb_regdst | input | 1 | Write-back destination is rd (1) or rt (0) |
| wb_regwrite | input | 1 | Write-back instruction writes a register |
| wb_memwrite | input | 1 | Write-back instruction is a store |
| wb_alu_result | input | 32 | Write-back-stage ALU result |
| wb_load_data | input | 32 | Write-back-stage load data |
| rf_rs_data | input | 32 | Register-file value for rs |
| rf_rt_data | input | 32 | Register-file value for rt |
| opnd_a | output | 32 | Selected first operand |
| opnd_b | output | 32 | Selected second operand |
| fwd_a | output | 1 | First operand was bypassed |
| fwd_b | output | 1 | Second operand was bypassed |

## Verification
The bench targets the following cases:

- **Both stages match the same source.** A design with the priority reversed returns the older write-back value.
- **A store in each of the three stages.** A design that misses one stage forwards a value while the pipeline moves data to memory.
- **Memory-stage match on rt while the ALU-source control is 1.** A design that ignores that control wrongly sets the second flag.
- **Write-back matches under ALU-op code 3 and under other codes.** A swapped data choice puts load data where the ALU result belongs, or bypasses rt when it must not.
- **Destination register 0 and producers with register-write off.** Handling either wrongly produces false bypasses.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2
  } fwd_src_e;

  // true when any of the three in-flight stages holds a store
  function automatic logic any_store(input logic ex_st, input logic mem_st,
                                     input logic wb_st);
    return ex_st | mem_st | wb_st;
  endfunction

endpackage

// File: rtl/fwd_dest_pick.sv
module fwd_dest_pick #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rt,
  input  logic [REG_AW-1:0] rd,
  input  logic              regdst,
  input  logic              regwrite,
  input  logic              blocked,
  output logic [REG_AW-1:0] dst,
  output logic              live
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  function automatic logic [REG_AW-1:0] pick(input logic [REG_AW-1:0] f_rt,
                                             input logic [REG_AW-1:0] f_rd,
                                             input logic use_rd);
    return use_rd ? f_rd : f_rt;
  endfunction

  always_comb begin
    dst  = pick(rt, rd, regdst);
    live = regwrite && !blocked && (dst != ZERO_REG);
  end

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int  XLEN      = 32,
  parameter int  REG_AW    = 5,
  parameter int  OP_W      = 2,
  parameter int  IMM_CLASS = 3,
  parameter bit  SECOND    = 1'b0
) (
  input  logic [REG_AW-1:0] src_reg,
  input  logic              alusrc,
  input  logic [OP_W-1:0]   aluop,
  input  logic              mem_live,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              wb_live,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic [XLEN-1:0]   mem_alu,
  input  logic [XLEN-1:0]   wb_alu,
  input  logic [XLEN-1:0]   wb_load,
  input  logic [XLEN-1:0]   rf_data,
  output logic [XLEN-1:0]   operand,
  output logic              fwd,
  output fwd_src_e          src
);

  localparam logic [OP_W-1:0] IMM_CODE = OP_W'(IMM_CLASS);

  logic            mem_hit;
  logic            wb_hit;
  logic            imm_consumer;
  logic            mem_take;
  logic            wb_take;
  logic [XLEN-1:0] wb_data;

  always_comb begin
    mem_hit      = mem_live && (mem_dst == src_reg);
    wb_hit       = wb_live && (wb_dst == src_reg);
    imm_consumer = (aluop == IMM_CODE);
    if (SECOND) begin
      mem_take = mem_hit && !alusrc;
      wb_take  = wb_hit && !imm_consumer;
      wb_data  = wb_load;
    end else begin
      mem_take = mem_hit;
      wb_take  = wb_hit;
      wb_data  = imm_consumer ? wb_alu : wb_load;
    end
  end

  always_comb begin
    if (mem_take) begin
      src     = SRC_MEM;
      operand = mem_alu;
    end else if (wb_take) begin
      src     = SRC_WB;
      operand = wb_data;
    end else begin
      src     = SRC_RF;
      operand = rf_data;
    end
    fwd = (src != SRC_RF);

    if (mem_take && wb_hit)
      a_r4_mem_over_wb: assert (src == SRC_MEM)
        else $error("R4: write-back won over memory stage");
    if (src == SRC_MEM)
      a_r8_mem_gives_alu: assert (operand == mem_alu)
        else $error("R8: memory bypass did not carry ALU result");
    if (src_reg == '0)
      a_r9_zero_never: assert (!fwd)
        else $error("R9: register 0 was bypassed");
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_AW    = 5,
  parameter int OP_W      = 2,
  parameter int IMM_CLASS = 3
) (
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic              ex_alusrc,
  input  logic [OP_W-1:0]   ex_aluop,
  input  logic              ex_memwrite,
  input  logic [REG_AW-1:0] mem_rt,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_regdst,
  input  logic              mem_regwrite,
  input  logic              mem_memwrite,
  input  logic [XLEN-1:0]   mem_alu_result,
  input  logic [REG_AW-1:0] wb_rt,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_regdst,
  input  logic              wb_regwrite,
  input  logic              wb_memwrite,
  input  logic [XLEN-1:0]   wb_alu_result,
  input  logic [XLEN-1:0]   wb_load_data,
  input  logic [XLEN-1:0]   rf_rs_data,
  input  logic [XLEN-1:0]   rf_rt_data,
  output logic [XLEN-1:0]   opnd_a,
  output logic [XLEN-1:0]   opnd_b,
  output logic              fwd_a,
  output logic              fwd_b
);

  localparam int N_OPND = 2;
  localparam logic [OP_W-1:0] IMM_CODE = OP_W'(IMM_CLASS);

  logic              store_block;
  logic [REG_AW-1:0] mem_dst;
  logic              mem_live;
  logic [REG_AW-1:0] wb_dst;
  logic              wb_live;

  logic [REG_AW-1:0] src_regs [N_OPND];
  logic [XLEN-1:0]   rf_vals  [N_OPND];
  logic [XLEN-1:0]   opnds    [N_OPND];
  logic              flags    [N_OPND];
  fwd_src_e          srcs     [N_OPND];

  assign store_block = any_store(ex_memwrite, mem_memwrite, wb_memwrite);

  fwd_dest_pick #(.REG_AW(REG_AW)) u_mem_dst (
    .rt(mem_rt), .rd(mem_rd), .regdst(mem_regdst),
    .regwrite(mem_regwrite), .blocked(store_block),
    .dst(mem_dst), .live(mem_live)
  );

  fwd_dest_pick #(.REG_AW(REG_AW)) u_wb_dst (
    .rt(wb_rt), .rd(wb_rd), .regdst(wb_regdst),
    .regwrite(wb_regwrite), .blocked(store_block),
    .dst(wb_dst), .live(wb_live)
  );

  assign src_regs[0] = ex_rs;
  assign src_regs[1] = ex_rt;
  assign rf_vals[0]  = rf_rs_data;
  assign rf_vals[1]  = rf_rt_data;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_operand_sel #(
      .XLEN(XLEN), .REG_AW(REG_AW), .OP_W(OP_W),
      .IMM_CLASS(IMM_CLASS), .SECOND(g == 1)
    ) u_sel (
      .src_reg(src_regs[g]), .alusrc(ex_alusrc), .aluop(ex_aluop),
      .mem_live(mem_live), .mem_dst(mem_dst),
      .wb_live(wb_live), .wb_dst(wb_dst),
      .mem_alu(mem_alu_result), .wb_alu(wb_alu_result),
      .wb_load(wb_load_data), .rf_data(rf_vals[g]),
      .operand(opnds[g]), .fwd(flags[g]), .src(srcs[g])
    );
  end

  assign opnd_a = opnds[0];
  assign opnd_b = opnds[1];
  assign fwd_a  = flags[0];
  assign fwd_b  = flags[1];

  always_comb begin
    if (store_block)
      a_r3_store_block: assert (!fwd_a && !fwd_b)
        else $error("R3: bypass while a store is in flight");
    if (ex_aluop == IMM_CODE)
      a_r6_b_no_wb_imm: assert (srcs[1] != SRC_WB)
        else $error("R6: rt bypassed from write-back on immediate op");
    if (ex_alusrc)
      a_r7_b_mem_reg_only: assert (srcs[1] != SRC_MEM)
        else $error("R7: rt bypassed from memory while immediate selected");
    if (!mem_regwrite && !wb_regwrite)
      a_r2_no_writer: assert (!fwd_a && !fwd_b)
        else $error("R2: bypass with no register writer");
  end

endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  ex_rs, ex_rt, mem_rt, mem_rd, wb_rt, wb_rd;
  logic        ex_alusrc, ex_memwrite, mem_regdst, mem_regwrite, mem_memwrite;
  logic        wb_regdst, wb_regwrite, wb_memwrite;
  logic [1:0]  ex_aluop;
  logic [31:0] mem_alu_result, wb_alu_result, wb_load_data, rf_rs_data, rf_rt_data;
  logic [31:0] opnd_a, opnd_b;
  logic        fwd_a, fwd_b;

  int n_cmp = 0;
  int n_bad = 0;

  fwd_unit dut_i (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_alusrc(ex_alusrc), .ex_aluop(ex_aluop),
    .ex_memwrite(ex_memwrite), .mem_rt(mem_rt), .mem_rd(mem_rd),
    .mem_regdst(mem_regdst), .mem_regwrite(mem_regwrite),
    .mem_memwrite(mem_memwrite), .mem_alu_result(mem_alu_result),
    .wb_rt(wb_rt), .wb_rd(wb_rd), .wb_regdst(wb_regdst),
    .wb_regwrite(wb_regwrite), .wb_memwrite(wb_memwrite),
    .wb_alu_result(wb_alu_result), .wb_load_data(wb_load_data),
    .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  // reference results
  logic [31:0] exp_a, exp_b;
  logic        exp_fa, exp_fb;
  string       why_a, why_b;

  task automatic clear_inputs();
    ex_rs = 0; ex_rt = 0; ex_alusrc = 0; ex_aluop = 2; ex_memwrite = 0;
    mem_rt = 0; mem_rd = 0; mem_regdst = 0; mem_regwrite = 0; mem_memwrite = 0;
    wb_rt = 0; wb_rd = 0; wb_regdst = 0; wb_regwrite = 0; wb_memwrite = 0;
    mem_alu_result = 32'hA000_0001; wb_alu_result = 32'hB000_0002;
    wb_load_data = 32'hC000_0003; rf_rs_data = 32'h1111_0004;
    rf_rt_data = 32'h2222_0005;
  endtask

  // behavioural model, built from the requirement list
  task automatic model();
    int  d_mem, d_wb;
    bit  stores, ok_mem, ok_wb, imm;
    d_mem  = mem_regdst ? int'(mem_rd) : int'(mem_rt);   // R1
    d_wb   = wb_regdst ? int'(wb_rd) : int'(wb_rt);
    stores = (ex_memwrite + mem_memwrite + wb_memwrite) > 0;
    ok_mem = mem_regwrite && !stores && d_mem != 0;      // R2 R3 R9
    ok_wb  = wb_regwrite && !stores && d_wb != 0;
    imm    = (ex_aluop == 2'd3);
    exp_a = rf_rs_data; exp_fa = 0; why_a = stores ? "R3" : "R10";
    if (ok_wb && d_wb == int'(ex_rs)) begin
      exp_a = imm ? wb_alu_result : wb_load_data; exp_fa = 1; why_a = "R5";
    end
    if (ok_mem && d_mem == int'(ex_rs)) begin
      exp_a = mem_alu_result; exp_fa = 1;
      why_a = (why_a == "R5") ? "R4" : "R8";
    end
    exp_b = rf_rt_data; exp_fb = 0; why_b = stores ? "R3" : "R10";
    if (ok_wb && d_wb == int'(ex_rt)) begin
      why_b = "R6";
      if (!imm) begin exp_b = wb_load_data; exp_fb = 1; end
    end
    if (ok_mem && d_mem == int'(ex_rt)) begin
      if (!ex_alusrc) begin
        exp_b = mem_alu_result; exp_fb = 1;
        why_b = (why_b == "R6" && !imm) ? "R4" : "R8";
      end else why_b = "R7";
    end
  endtask

  task automatic chk32(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  // apply current inputs at a fresh cycle, compare away from the edge
  task automatic step(string tag);
    @(posedge clk);
    #1;
    model();
    @(negedge clk);
    chk32((tag == "") ? why_a : tag, "opnd_a", opnd_a, exp_a);
    chk32((tag == "") ? why_b : tag, "opnd_b", opnd_b, exp_b);
    chk32((tag == "") ? why_a : {tag, "/R11"}, "fwd_a", {31'd0, fwd_a}, {31'd0, exp_fa});
    chk32((tag == "") ? why_b : {tag, "/R11"}, "fwd_b", {31'd0, fwd_b}, {31'd0, exp_fb});
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    clear_inputs();
    step("R10");                                                   // idle state
    clear_inputs(); ex_rs = 7; mem_rd = 7; mem_rt = 3; mem_regdst = 1; mem_regwrite = 1;
    step("R1");                                                    // rd path
    clear_inputs(); ex_rs = 7; mem_rd = 3; mem_rt = 7; mem_regdst = 0; mem_regwrite = 1;
    step("R1");                                                    // rt path
    clear_inputs(); ex_rs = 7; ex_rt = 7; mem_rd = 7; mem_regdst = 1;
    wb_rd = 7; wb_regdst = 1;
    step("R2");                                                    // no writers
    clear_inputs(); ex_rs = 9; ex_rt = 9; mem_rd = 9; mem_regdst = 1; mem_regwrite = 1;
    ex_memwrite = 1;
    step("R3");
    ex_memwrite = 0; wb_memwrite = 1;
    step("R3");
    wb_memwrite = 0; mem_memwrite = 1;
    step("R3");
    clear_inputs(); ex_rs = 5; ex_rt = 5; mem_rd = 5; mem_regdst = 1; mem_regwrite = 1;
    wb_rd = 5; wb_regdst = 1; wb_regwrite = 1;
    step("R4");
    clear_inputs(); ex_rs = 4; wb_rt = 4; wb_regwrite = 1; ex_aluop = 3;
    step("R5");                                                    // ALU result
    ex_aluop = 2;
    step("R5");                                                    // load data
    clear_inputs(); ex_rt = 6; wb_rt = 6; wb_regwrite = 1; ex_aluop = 3;
    step("R6");
    ex_aluop = 0;
    step("R6");
    clear_inputs(); ex_rs = 8; ex_rt = 8; mem_rt = 8; mem_regwrite = 1; ex_alusrc = 1;
    step("R7");
    ex_alusrc = 0;
    step("R8");
    clear_inputs(); ex_rs = 0; ex_rt = 0; mem_regwrite = 1; wb_regwrite = 1;
    step("R9");
    for (int i = 0; i < 3000; i++) begin
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
      mem_rt = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
      wb_rt = 5'($urandom_range(0, 3)); wb_rd = 5'($urandom_range(0, 3));
      ex_alusrc = 1'($urandom); ex_aluop = 2'($urandom);
      ex_memwrite = ($urandom_range(0, 7) == 0);
      mem_memwrite = ($urandom_range(0, 7) == 0);
      wb_memwrite = ($urandom_range(0, 7) == 0);
      mem_regdst = 1'($urandom); mem_regwrite = 1'($urandom);
      wb_regdst = 1'($urandom); wb_regwrite = 1'($urandom);
      mem_alu_result = $urandom; wb_alu_result = $urandom;
      wb_load_data = $urandom; rf_rs_data = $urandom; rf_rt_data = $urandom;
      step("");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule